// File: doc/BRIEF.md
# Error Type Classification Controller

This controller sits beside a memory traffic generator and decides where a data compare failure came from. While error checking is enabled, the first compare error seen during normal traffic is logged with its address and the data that was expected there. In stop mode the controller then withholds traffic and waits for the traffic in flight to drain. It then re-reads the logged address a fixed number of times (1024 by default) through a simple request/grant and return-valid read port.

Each returned word is compared with the logged expected word and with the first word that came back. The failure counts as a WRITE error only when no returned word matches the expectation and every returned word is identical. That pattern means the wrong value is really stored in the memory. Any other pattern counts as a READ error. The verdict is then published with a valid flag and the controller parks in a done state. A restart pulse clears everything from there, and a continue pulse lets traffic run on with the verdict kept. In continue mode the first error is only logged and traffic never stops. To restart in that mode, raise pause, pulse restart, then drop pause.

Top module: `errclass_ctrl`

## Requirements
- R1: While `chk_en_i` is low, a compare error is ignored: nothing is logged and traffic keeps running.
- R2: In stop mode (`stop_mode_i` high), the first logged error drops `traffic_en_o` on the next cycle. No check read is requested until `traffic_idle_i` is high.
- R3: The read-check issues exactly `CHECK_READS` accepted read requests, all to the logged first-error address.
- R4: `err_type_o` is 1 (WRITE) when every returned word differs from the logged expected word and all returned words are equal. In all other cases it is 0 (READ), including when only the first or only the last word breaks the pattern.
- R5: When the last check read returns, the controller enters the done state and raises `err_type_vld_o`.
- R6: In the done state, a restart pulse clears the log and the verdict and goes to idle. Otherwise a continue pulse returns to running traffic with the verdict kept, and no further classification takes place until a restart.
- R7: In continue mode (`stop_mode_i` low), errors never stop traffic. Only the first error's address and expected data are logged, and no check reads are issued.
- R8: A restart pulse is ignored while running. With pause held, restart clears the log and the controller stays idle until pause is released, then runs.
- R9: `state_o` encodes idle=0, run=1, drain=2, read-check=3, done=4, pause=5. After reset it reads 0 and goes to 1 on the first clock with pause low.
- R10: `first_addr_o` and `first_exp_o` hold the address and expected data of the first logged error, and `err_logged_o` is high while a log is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_en_i | input | 1 | Error checking enable |
| stop_mode_i | input | 1 | 1: stop and classify on first error; 0: continue with error |
| pause_i | input | 1 | Pause traffic |
| restart_i | input | 1 | Restart pulse |
| continue_i | input | 1 | Continue pulse from the done state |
| cmp_err_i | input | 1 | Compare error strobe from the traffic checker |
| cmp_addr_i | input | ADDR_W | Address of the failing access |
| cmp_exp_i | input | DATA_W | Expected data of the failing access |
| traffic_idle_i | input | 1 | No normal traffic outstanding |
| traffic_en_o | output | 1 | Normal traffic allowed |
| rd_req_o | output | 1 | Check read request |
| rd_addr_o | output | ADDR_W | Check read address |
| rd_gnt_i | input | 1 | Check read request accepted |
| rd_vld_i | input | 1 | Check read data valid |
| rd_data_i | input | DATA_W | Check read data |
| err_logged_o | output | 1 | A first error is logged |
| first_addr_o | output | ADDR_W | Logged first-error address |
| first_exp_o | output | DATA_W | Logged first-error expected data |
| err_type_o | output | 1 | 1 = WRITE error, 0 = READ error |
| err_type_vld_o | output | 1 | Verdict valid |
| state_o | output | 3 | Controller state code |

## Verification
A state register stuck in the wrong place shows on `state_o` and `traffic_en_o` one cycle after the triggering pulse or error. The bench samples both right after every stimulus. A fault in the read count or the compare flags shows only at the end of the check, as a wrong number of accepted requests or a wrong `err_type_o`. The stimulus patterns therefore put the one deviating word at the first, a middle and the last position. A missed drain wait shows as a request seen in the cycles before `traffic_idle_i` rises.

// File: rtl/errclass_pkg.sv
package errclass_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_DRAIN = 3'd2,
        ST_CHECK = 3'd3,
        ST_DONE  = 3'd4,
        ST_PAUSE = 3'd5
    } ec_state_e;

endpackage

// File: rtl/errclass_issue.sv
module errclass_issue #(
    parameter int N  = 1024,
    parameter int CW = $clog2(N + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic gnt_i,
    output logic req_o
);
    logic [CW-1:0] sent_d, sent_q;

    always_comb begin
        req_o  = active_i && (sent_q < CW'(N));
        sent_d = sent_q;
        if (!active_i) begin
            sent_d = '0;
        end else if (req_o && gnt_i) begin
            sent_d = sent_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sent_q <= '0;
        else        sent_q <= sent_d;
    end
endmodule

// File: rtl/errclass_judge.sv
module errclass_judge #(
    parameter int N      = 1024,
    parameter int DATA_W = 32,
    parameter int CW     = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              vld_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] exp_i,
    output logic              done_o,
    output logic              verdict_o
);
    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic [DATA_W-1:0] first;
        logic              all_differ;
        logic              all_equal;
    } judge_t;

    judge_t j_d, j_q;
    logic              is_first;
    logic [DATA_W-1:0] ref_word;
    logic              differ_n, equal_n;

    always_comb begin
        is_first  = (j_q.cnt == '0);
        ref_word  = is_first ? data_i : j_q.first;
        differ_n  = j_q.all_differ && (data_i != exp_i);
        equal_n   = j_q.all_equal && (data_i == ref_word);
        verdict_o = differ_n && equal_n;
        done_o    = active_i && vld_i && (j_q.cnt == CW'(N - 1));
        j_d       = j_q;
        if (!active_i) begin
            j_d.cnt        = '0;
            j_d.first      = '0;
            j_d.all_differ = 1'b1;
            j_d.all_equal  = 1'b1;
        end else if (vld_i) begin
            j_d.cnt        = j_q.cnt + CW'(1);
            j_d.first      = ref_word;
            j_d.all_differ = differ_n;
            j_d.all_equal  = equal_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            j_q.cnt        <= '0;
            j_q.first      <= '0;
            j_q.all_differ <= 1'b1;
            j_q.all_equal  <= 1'b1;
        end else begin
            j_q <= j_d;
        end
    end
endmodule

// File: rtl/errclass_ctrl.sv
module errclass_ctrl
    import errclass_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int CHECK_READS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_en_i,
    input  logic              stop_mode_i,
    input  logic              pause_i,
    input  logic              restart_i,
    input  logic              continue_i,
    input  logic              cmp_err_i,
    input  logic [ADDR_W-1:0] cmp_addr_i,
    input  logic [DATA_W-1:0] cmp_exp_i,
    input  logic              traffic_idle_i,
    output logic              traffic_en_o,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_gnt_i,
    input  logic              rd_vld_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              err_logged_o,
    output logic [ADDR_W-1:0] first_addr_o,
    output logic [DATA_W-1:0] first_exp_o,
    output logic              err_type_o,
    output logic              err_type_vld_o,
    output logic [2:0]        state_o
);
    localparam int CW = $clog2(CHECK_READS + 1);

    typedef struct packed {
        ec_state_e         st;
        logic              logged;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] exp;
        logic              etype;
        logic              tvld;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  check_active;
    logic  judge_done, judge_verdict;

    assign check_active = (c_q.st == ST_CHECK);

    errclass_issue #(.N(CHECK_READS), .CW(CW)) i_issue (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (check_active),
        .gnt_i    (rd_gnt_i),
        .req_o    (rd_req_o)
    );

    errclass_judge #(.N(CHECK_READS), .DATA_W(DATA_W), .CW(CW)) i_judge (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (check_active),
        .vld_i     (rd_vld_i),
        .data_i    (rd_data_i),
        .exp_i     (c_q.exp),
        .done_o    (judge_done),
        .verdict_o (judge_verdict)
    );

    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            ST_IDLE: begin
                if (!pause_i) c_d.st = ST_RUN;
            end
            ST_RUN: begin
                if (pause_i) begin
                    c_d.st = ST_PAUSE;
                end else if (cmp_err_i && chk_en_i && !c_q.logged) begin
                    c_d.logged = 1'b1;
                    c_d.addr   = cmp_addr_i;
                    c_d.exp    = cmp_exp_i;
                    if (stop_mode_i) c_d.st = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (traffic_idle_i) c_d.st = ST_CHECK;
            end
            ST_CHECK: begin
                if (judge_done) begin
                    c_d.st    = ST_DONE;
                    c_d.etype = judge_verdict;
                    c_d.tvld  = 1'b1;
                end
            end
            ST_DONE: begin
                if (restart_i) begin
                    c_d.st     = ST_IDLE;
                    c_d.logged = 1'b0;
                    c_d.addr   = '0;
                    c_d.exp    = '0;
                    c_d.etype  = 1'b0;
                    c_d.tvld   = 1'b0;
                end else if (continue_i) begin
                    c_d.st = ST_RUN;
                end
            end
            ST_PAUSE: begin
                if (restart_i) begin
                    c_d.st     = ST_IDLE;
                    c_d.logged = 1'b0;
                    c_d.addr   = '0;
                    c_d.exp    = '0;
                    c_d.etype  = 1'b0;
                    c_d.tvld   = 1'b0;
                end else if (!pause_i) begin
                    c_d.st = ST_RUN;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.st     <= ST_IDLE;
            c_q.logged <= 1'b0;
            c_q.addr   <= '0;
            c_q.exp    <= '0;
            c_q.etype  <= 1'b0;
            c_q.tvld   <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign traffic_en_o   = (c_q.st == ST_RUN);
    assign rd_addr_o      = c_q.addr;
    assign err_logged_o   = c_q.logged;
    assign first_addr_o   = c_q.addr;
    assign first_exp_o    = c_q.exp;
    assign err_type_o     = c_q.etype;
    assign err_type_vld_o = c_q.tvld;
    assign state_o        = c_q.st;
endmodule

// File: rtl/errclass_checker.sv
module errclass_checker #(
    parameter int N = 1024
) (
    input logic       clk,
    input logic       rst_n,
    input logic       chk_en_i,
    input logic       restart_i,
    input logic       continue_i,
    input logic       rd_req_o,
    input logic       rd_gnt_i,
    input logic       traffic_en_o,
    input logic       err_logged_o,
    input logic       err_type_vld_o,
    input logic [2:0] state_o
);
    localparam int CW = $clog2(N + 1);
    logic [CW-1:0] req_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)               req_cnt_q <= '0;
        else if (state_o != 3'd3) req_cnt_q <= '0;
        else if (rd_req_o && rd_gnt_i) req_cnt_q <= req_cnt_q + CW'(1);
    end

    a_r3_req_only_in_check: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> state_o == 3'd3);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        req_cnt_q <= CW'(N));

    a_r3_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_type_vld_o) |-> req_cnt_q == CW'(N));

    a_r5_done_on_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_type_vld_o) |-> state_o == 3'd4);

    a_r2_traffic_halted: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 || state_o == 3'd3 || state_o == 3'd4) |-> !traffic_en_o);

    a_r6_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4 && restart_i) |=> (state_o == 3'd0 && !err_type_vld_o && !err_logged_o));

    a_r6_continue_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4 && continue_i && !restart_i) |=> state_o == 3'd1);

    a_r1_no_log_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && !chk_en_i && !err_logged_o) |=> !err_logged_o);
endmodule

bind errclass_ctrl errclass_checker #(.N(CHECK_READS)) i_errclass_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .chk_en_i       (chk_en_i),
    .restart_i      (restart_i),
    .continue_i     (continue_i),
    .rd_req_o       (rd_req_o),
    .rd_gnt_i       (rd_gnt_i),
    .traffic_en_o   (traffic_en_o),
    .err_logged_o   (err_logged_o),
    .err_type_vld_o (err_type_vld_o),
    .state_o        (state_o)
);

// File: tb/test_errclass_ctrl.sv
`timescale 1ns/1ps
module test_errclass_ctrl;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int N  = 1024;
    localparam logic [DW-1:0] EXPW = 32'hA5A5_0F0F;
    localparam logic [DW-1:0] BADW = 32'h1234_5678;
    localparam logic [AW-1:0] ADR0 = 32'h0000_1F40;

    // {pattern mode[3:0], expected err_type (1=WRITE)}
    localparam logic [4:0] VEC [6] = '{
        {4'd0, 1'b1},   // constant wrong word
        {4'd1, 1'b0},   // every read matches expected
        {4'd2, 1'b0},   // one middle read differs from the rest
        {4'd3, 1'b0},   // first read matches expected
        {4'd4, 1'b0},   // last read matches expected
        {4'd5, 1'b0}    // last read differs from first
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chk_en_i = 1'b1, stop_mode_i = 1'b1, pause_i = 1'b0;
    logic restart_i = 1'b0, continue_i = 1'b0, cmp_err_i = 1'b0;
    logic [AW-1:0] cmp_addr_i = '0;
    logic [DW-1:0] cmp_exp_i = '0;
    logic traffic_idle_i = 1'b0;
    logic traffic_en_o, rd_req_o, rd_vld_i, err_logged_o, err_type_o, err_type_vld_o;
    logic rd_gnt_i;
    logic [AW-1:0] rd_addr_o, first_addr_o;
    logic [DW-1:0] rd_data_i, first_exp_o;
    logic [2:0] state_o;

    int checks = 0, fails = 0;
    int mode = 0, rd_idx = 0, req_cnt = 0, bad_addr = 0;
    logic pend = 1'b0;

    assign rd_gnt_i = 1'b1;
    always #10 clk = ~clk;

    errclass_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CHECK_READS(N)) i_errclass_ctrl (
        .clk(clk), .rst_n(rst_n), .chk_en_i(chk_en_i), .stop_mode_i(stop_mode_i),
        .pause_i(pause_i), .restart_i(restart_i), .continue_i(continue_i),
        .cmp_err_i(cmp_err_i), .cmp_addr_i(cmp_addr_i), .cmp_exp_i(cmp_exp_i),
        .traffic_idle_i(traffic_idle_i), .traffic_en_o(traffic_en_o),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_gnt_i(rd_gnt_i),
        .rd_vld_i(rd_vld_i), .rd_data_i(rd_data_i), .err_logged_o(err_logged_o),
        .first_addr_o(first_addr_o), .first_exp_o(first_exp_o),
        .err_type_o(err_type_o), .err_type_vld_o(err_type_vld_o), .state_o(state_o)
    );

    function automatic logic [DW-1:0] word_of(int m, int i);
        case (m)
            0: return BADW;
            1: return EXPW;
            2: return (i == 500) ? (BADW ^ 32'h1) : BADW;
            3: return (i == 0) ? EXPW : BADW;
            4: return (i == N - 1) ? EXPW : BADW;
            default: return (i == N - 1) ? (BADW ^ 32'h8) : BADW;
        endcase
    endfunction

    // read responder: one cycle from accepted request to data
    initial begin
        rd_vld_i  = 1'b0;
        rd_data_i = '0;
        forever begin
            @(negedge clk);
            #1;
            rd_vld_i  = pend;
            rd_data_i = word_of(mode, rd_idx);
            if (pend) rd_idx++;
            pend = rd_req_o;
            if (rd_req_o) begin
                req_cnt++;
                if (rd_addr_o != cmp_addr_i) bad_addr++;
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pause_i = 1'b0; restart_i = 1'b0; continue_i = 1'b0; cmp_err_i = 1'b0;
        traffic_idle_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        pend = 1'b0; rd_idx = 0; req_cnt = 0; bad_addr = 0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic inject(input logic [AW-1:0] a, input logic [DW-1:0] e);
        cmp_err_i = 1'b1; cmp_addr_i = a; cmp_exp_i = e;
        @(negedge clk);
        cmp_err_i = 1'b0;
    endtask

    task automatic pulse_restart();
        restart_i = 1'b1;
        @(negedge clk);
        restart_i = 1'b0;
    endtask

    task automatic pulse_continue();
        continue_i = 1'b1;
        @(negedge clk);
        continue_i = 1'b0;
    endtask

    task automatic wait_verdict();
        for (int i = 0; i < 4000 && !err_type_vld_o; i++) @(negedge clk);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        report();
    end

    initial begin
        // R9 reset state
        repeat (3) @(negedge clk);
        chk(state_o == 3'd0 && !traffic_en_o && !err_type_vld_o && !err_logged_o,
            "R9 reset state", state_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(state_o == 3'd1 && traffic_en_o, "R9 run after reset", state_o, 1);

        // table of classification patterns
        for (int v = 0; v < 6; v++) begin
            do_reset();
            mode = int'(VEC[v][4:1]);
            chk_en_i = 1'b1; stop_mode_i = 1'b1;
            inject(ADR0 + AW'(v * 64), EXPW);
            chk(state_o == 3'd2 && !traffic_en_o, "R2 stop after first error", state_o, 2);
            repeat (5) @(negedge clk);
            chk(req_cnt == 0 && state_o == 3'd2, "R2 no read before drain", req_cnt, 0);
            traffic_idle_i = 1'b1;
            wait_verdict();
            chk(err_type_vld_o && state_o == 3'd4, "R5 done with valid", state_o, 4);
            chk(err_type_o == VEC[v][0], "R4 verdict", err_type_o, VEC[v][0]);
            chk(req_cnt == N, "R3 read count", req_cnt, N);
            chk(bad_addr == 0, "R3 read address", bad_addr, 0);
            chk(first_addr_o == ADR0 + AW'(v * 64) && first_exp_o == EXPW && err_logged_o,
                "R10 first error log", first_addr_o, ADR0 + AW'(v * 64));
        end

        // R1 checking disabled
        do_reset();
        chk_en_i = 1'b0; stop_mode_i = 1'b1;
        inject(32'h44, EXPW);
        @(negedge clk);
        chk(state_o == 3'd1 && traffic_en_o && !err_logged_o, "R1 error ignored", err_logged_o, 0);
        chk_en_i = 1'b1;

        // R7 continue-with-error mode
        do_reset();
        stop_mode_i = 1'b0;
        inject(32'hA1, EXPW);
        chk(state_o == 3'd1 && traffic_en_o && err_logged_o, "R7 traffic keeps running", state_o, 1);
        inject(32'hA2, ~EXPW);
        repeat (3) @(negedge clk);
        chk(first_addr_o == 32'hA1 && first_exp_o == EXPW, "R7 only first error logged", first_addr_o, 32'hA1);
        chk(!err_type_vld_o && req_cnt == 0, "R7 no classification", req_cnt, 0);

        // R8 restart ignored in run, pause/restart/release sequence
        pulse_restart();
        chk(err_logged_o && state_o == 3'd1, "R8 restart ignored while running", err_logged_o, 1);
        pause_i = 1'b1;
        @(negedge clk);
        chk(state_o == 3'd5 && !traffic_en_o, "R9 pause state", state_o, 5);
        pulse_restart();
        chk(state_o == 3'd0 && !err_logged_o, "R8 restart clears under pause", state_o, 0);
        repeat (2) @(negedge clk);
        chk(state_o == 3'd0, "R8 idle while pause held", state_o, 0);
        pause_i = 1'b0;
        @(negedge clk);
        chk(state_o == 3'd1 && traffic_en_o, "R8 run after pause release", state_o, 1);

        // R6 continue from done, then restart from done
        do_reset();
        stop_mode_i = 1'b1; mode = 0; traffic_idle_i = 1'b1;
        inject(ADR0, EXPW);
        wait_verdict();
        pulse_continue();
        chk(state_o == 3'd1 && traffic_en_o && err_type_vld_o && err_type_o,
            "R6 continue resumes with verdict kept", state_o, 1);
        inject(32'h88, EXPW);
        @(negedge clk);
        chk(state_o == 3'd1 && first_addr_o == ADR0, "R6 no reclassify after continue", state_o, 1);
        pause_i = 1'b1;
        @(negedge clk);
        pulse_restart();
        pause_i = 1'b0;
        @(negedge clk);
        pend = 1'b0; rd_idx = 0; req_cnt = 0;
        inject(ADR0, EXPW);
        wait_verdict();
        chk(state_o == 3'd4 && req_cnt == N, "R6 new classification after restart", req_cnt, N);
        pulse_restart();
        chk(state_o == 3'd0 && !err_type_vld_o && !err_logged_o, "R6 restart from done clears", state_o, 0);
        @(negedge clk);
        chk(state_o == 3'd1, "R6 runs after restart", state_o, 1);

        report();
    end
endmodule